// File: doc/BRIEF.md
# Sequential Block-Transfer Configuration Register Slave

This block is a two-wire serial bus slave that owns a bank of seven 8-bit configuration registers and presents all of them in parallel to the logic around it. The bus is sampled with a fast system clock: SCL and SDA arrive as plain inputs, pass through a two-flop synchronizer, and bus conditions are recognized from edges of the synchronized signals. The slave drives SDA only by pulling it low, through an output enable that the pad turns into an open-drain driver.

There is no register addressing. A write transfer carries two leading bytes, a command byte and a count byte. Both are acknowledged and thrown away. Every byte after them lands in the next register, starting at register 0, and the master may end the transfer after any whole byte. A read transfer returns a count byte (the number of registers), then the registers from 0 upward. It ends when the master withholds its acknowledge. The bus runs at standard-mode speed or slower, so many system clock cycles fit in each SCL phase.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x00, registers 1 to 5 hold 0xFF, register 6 holds 0x06, and sda_oe is 0. Register k appears on cfg_regs_o bits [8k+7:8k].
- R2: A first byte of 0xD2 (7-bit address 0x69, R/W bit 0) or 0xD3 (R/W bit 1) after START is acknowledged by pulling SDA low during the ninth SCL pulse. Any other address byte is not acknowledged, and the slave ignores the bus until the next START.
- R3: In a write, the two bytes after the address are acknowledged and their values are not stored anywhere.
- R4: Write data bytes, sent MSB first, are stored in order into registers 0, 1, ... 6, and each one is acknowledged. A register changes only when a data byte aimed at it completes.
- R5: A STOP after any complete data byte leaves every register not yet reached unchanged. A byte cut short by STOP is not stored.
- R6: Data bytes after the seventh are acknowledged and change no register.
- R7: A read returns the count 7 and then registers 0 to 6, each MSB first. The slave changes its SDA drive only while SCL is low.
- R8: A master NACK ends a read. SDA then stays released until the next START. If the master acknowledges register 6, the byte that follows is 0xFF.
- R9: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are recognized at any point in a transfer. A repeated START restarts the address phase and the byte sequence.
- R10: The slave never drives SDA high, and it has released SDA after every STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs_o | output | 56 | Register k on bits [8k+7:8k] |

## Verification
Two functions can fall on the same byte boundary. One stores the seventh data byte. The other switches the sequence counter into its ignore range, and both are decided on the same SCL rising edge. A nine-byte write provokes this. Every byte must be acknowledged, and a later read must show exactly the first seven bytes with nothing shifted or lost. A second overlap comes when the release after a master NACK meets a new START: the bench NACKs early, clocks a full idle byte while watching that the line stays high, and then checks that the next transfer starts cleanly from the address phase.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  localparam int DW       = 8;
  localparam int NREG     = 7;
  localparam int HDR_LEN  = 2;
  localparam logic [6:0] DEV_ADDR = 7'h69;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } bus_st_e;

  // Power-on value of register idx in a bank of n registers.
  function automatic logic [DW-1:0] reg_reset_val(input int idx, input int n);
    if (idx == 0)          return '0;
    else if (idx == n - 1) return DW'(6);
    else                   return '1;
  endfunction

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/cfgslv_regfile.sv
module cfgslv_regfile
  import cfgslv_pkg::*;
#(
  parameter int NUM_REGS = NREG,
  parameter int CNT_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [CNT_W-1:0]       rd_seq,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_REGS*DW-1:0] regs_flat
);

  logic [DW-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= reg_reset_val(k, NUM_REGS);
    end else if (wr_stb) begin
      for (int k = 0; k < NUM_REGS; k++)
        if (wr_idx == IDX_W'(k)) regs[k] <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[g*DW +: DW] = regs[g];
    end
  endgenerate

  // Read sequence: 0 -> count, 1..NUM_REGS -> registers, beyond -> all ones.
  always_comb begin
    rd_data = '1;
    if (rd_seq == '0) rd_data = DW'(NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_seq == CNT_W'(k + 1)) rd_data = regs[k];
  end

endmodule

// File: rtl/cfgslv_fsm.sv
module cfgslv_fsm
  import cfgslv_pkg::*;
#(
  parameter int NUM_REGS      = NREG,
  parameter int HDR           = HDR_LEN,
  parameter logic [6:0] ADDR  = DEV_ADDR,
  parameter int CNT_W         = 4,
  localparam int IDX_W        = $clog2(NUM_REGS),
  localparam int BIT_W        = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [DW-1:0]    rd_data,
  output logic [CNT_W-1:0] seq_no,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Is byte number n (counted after the address) a storable data byte?
  function automatic logic hits_reg(input logic [CNT_W-1:0] n);
    return (n >= CNT_W'(HDR)) && (n < CNT_W'(HDR + NUM_REGS));
  endfunction

  // Register index addressed by byte number n.
  function automatic logic [IDX_W-1:0] reg_of(input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] d;
    d = n - CNT_W'(HDR);
    return d[IDX_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] n);
    return (n == CNT_MAX) ? n : n + 1'b1;
  endfunction

  bus_st_e          st;
  logic [BIT_W-1:0] bitcnt;
  logic [DW-2:0]    rx_sh;
  logic [DW-1:0]    tx_sh;
  logic             is_addr, is_read, ack_pend;
  logic [DW-1:0]    rx_byte;
  logic             byte_end;

  assign rx_byte  = {rx_sh, sda_q};
  assign byte_end = (st == ST_RX) && scl_rise && (bitcnt == BIT_W'(DW - 1));
  assign wr_stb   = byte_end && !is_addr && !is_read && hits_reg(seq_no);
  assign wr_idx   = reg_of(seq_no);
  assign wr_data  = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_addr  <= 1'b0;
      is_read  <= 1'b0;
      ack_pend <= 1'b0;
      seq_no   <= '0;
      sda_oe   <= 1'b0;
    end else if (start_evt) begin
      st       <= ST_RX;
      bitcnt   <= '0;
      is_addr  <= 1'b1;
      is_read  <= 1'b0;
      ack_pend <= 1'b0;
      seq_no   <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh  <= rx_byte[DW-2:0];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_W'(DW - 1)) begin
              if (is_addr) begin
                ack_pend <= (rx_byte[DW-1:1] == ADDR);
                is_read  <= rx_byte[0];
              end else begin
                ack_pend <= 1'b1;
                seq_no   <= sat_inc(seq_no);
              end
            end
          end else if (scl_fall && bitcnt == BIT_W'(DW)) begin
            bitcnt  <= '0;
            is_addr <= 1'b0;
            if (ack_pend) begin
              sda_oe <= 1'b1;
              st     <= ST_ACK;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (is_read) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              seq_no <= sat_inc(seq_no);
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == BIT_W'(DW)) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              st     <= ST_TXACK;
            end else begin
              tx_sh  <= tx_sh << 1;
              sda_oe <= ~tx_sh[DW-2];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            ack_pend <= ~sda_q;
          end else if (scl_fall) begin
            if (ack_pend) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              seq_no <= sat_inc(seq_no);
              st     <= ST_TX;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfgslv_pkg::*;
#(
  parameter int NUM_REGS     = NREG,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 4,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int OUT_W       = NUM_REGS * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [OUT_W-1:0] cfg_regs_o
);

  logic             scl_q, sda_q, scl_rise, scl_fall;
  logic             start_evt, stop_evt;
  logic             wr_stb;
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0]    wr_data, rd_data;
  logic [CNT_W-1:0] seq_no;

  cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfgslv_fsm #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .seq_no(seq_no), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfgslv_regfile #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_seq(seq_no), .rd_data(rd_data),
    .regs_flat(cfg_regs_o)
  );

endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
  parameter int NUM_REGS = 7,
  parameter int IDX_W    = 3,
  parameter int OUT_W    = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_q,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic [IDX_W-1:0] wr_idx,
  input logic [OUT_W-1:0] regs_o
);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R9
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt}));

  // R6
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(wr_idx) < NUM_REGS));

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_o));

  // R7
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

endmodule

bind cfg_i2c_slave cfgslv_chk #(
  .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_stb(wr_stb),
  .wr_idx(wr_idx), .regs_o(cfg_regs_o)
);

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 16;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [NR*8-1:0] regs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  cfg_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs_o(regs)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(); wait_q();
    chk(sda_oe == 1'b0, "R10 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    acked = (sda_line == 1'b0);
    wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b, output bit low_seen);
    low_seen = 1'b0;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(); scl = 1'b1; wait_q();
      b[i] = sda_line;
      wait_q(); scl = 1'b0; wait_q();
    end
    sda_m = ack ? 1'b0 : 1'b1;
    wait_q(); scl = 1'b1; wait_q();
    if (!ack && sda_line == 1'b0) low_seen = 1'b1;
    wait_q(); scl = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < NR; k++)
      chk(regs[k*8 +: 8] == exp_r[k], tag, 32'(regs[k*8 +: 8]), 32'(exp_r[k]));
  endtask

  task automatic write_seq(input logic [7:0] d [], input int n, input string tag);
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 write address ack", 32'(a), 1);
    send_byte(8'hC3, a); chk(a, "R3 command ack", 32'(a), 1);
    send_byte(8'h3C, a); chk(a, "R3 count ack", 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      chk(a, tag, 32'(a), 1);
      if (i < NR) exp_r[i] = d[i];
    end
    bus_stop();
  endtask

  task automatic t_reset();
    exp_r[0] = 8'h00;
    for (int k = 1; k < NR - 1; k++) exp_r[k] = 8'hFF;
    exp_r[NR-1] = 8'h06;
    check_regs("R1 reset value");
    chk(sda_oe == 1'b0, "R1 sda_oe at reset", 32'(sda_oe), 0);
  endtask

  task automatic t_full_write();
    logic [7:0] d [] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    write_seq(d, 7, "R4 data ack");
    check_regs("R4 R3 sequential store, header discarded");
  endtask

  task automatic t_partial();
    logic [7:0] d [] = '{8'hA1, 8'hB2};
    bit a;
    write_seq(d, 2, "R5 data ack");
    check_regs("R5 unreached registers kept");
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_bits(8'h5F, 4);
    bus_stop();
    check_regs("R5 partial byte not stored");
  endtask

  task automatic t_overflow();
    logic [7:0] d [] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'hE8, 8'hE9};
    write_seq(d, 9, "R6 every byte acked");
    check_regs("R6 extra bytes ignored");
  endtask

  task automatic t_read();
    bit a, lo;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); chk(a, "R2 read address ack", 32'(a), 1);
    recv_byte(1'b1, b, lo); chk(b == 8'd7, "R7 byte count", 32'(b), 7);
    for (int k = 0; k < NR; k++) begin
      recv_byte(1'b1, b, lo);
      chk(b == exp_r[k], "R7 register readback", 32'(b), 32'(exp_r[k]));
    end
    recv_byte(1'b0, b, lo);
    chk(b == 8'hFF, "R8 past end returns FF", 32'(b), 32'hFF);
    chk(!lo, "R8 released at NACK", 32'(lo), 0);
    bus_stop();
  endtask

  task automatic t_early_nack();
    bit a, lo;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, b, lo);
    chk(b == 8'd7, "R7 count before NACK", 32'(b), 7);
    recv_byte(1'b0, b, lo);
    chk(b == 8'hFF, "R8 line released after NACK", 32'(b), 32'hFF);
    bus_stop();
    bus_start();
    send_byte(8'hD3, a); chk(a, "R9 START rearms after NACK", 32'(a), 1);
    recv_byte(1'b0, b, lo); chk(b == 8'd7, "R9 sequence restarted", 32'(b), 7);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R2 foreign address not acked", 32'(a), 0);
    send_byte(8'h00, a); chk(!a, "R2 ignored until START", 32'(a), 0);
    send_byte(8'h9C, a);
    bus_stop();
    check_regs("R2 foreign transfer stores nothing");
  endtask

  task automatic t_rstart();
    bit a, lo;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h10, a); send_byte(8'h20, a);
    send_byte(8'h5A, a); exp_r[0] = 8'h5A;
    bus_start();
    send_byte(8'hD3, a); chk(a, "R9 repeated START read address", 32'(a), 1);
    recv_byte(1'b1, b, lo); chk(b == 8'd7, "R9 count after repeated START", 32'(b), 7);
    recv_byte(1'b0, b, lo); chk(b == 8'h5A, "R9 reg0 after repeated START", 32'(b), 32'h5A);
    bus_start();
    send_byte(8'hD2, a); send_byte(8'hFF, a);
    bus_start();
    send_byte(8'hD2, a); send_byte(8'hFF, a); send_byte(8'hFF, a);
    send_byte(8'hC7, a); exp_r[0] = 8'hC7;
    bus_stop();
    check_regs("R9 header restarts after repeated START");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_partial();
    t_overflow();
    t_read();
    t_early_nack();
    t_bad_addr();
    t_rstart();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule